// File: doc/BRIEF.md
# Interrupt Cause and Mask Aggregator

This block gathers up to twenty-nine interrupt event lines into one sticky cause word. It also keeps a mask word that enables each source, and it presents a single prioritised interrupt request to a processor. Any event line seen high on a clock edge latches its cause bit. The bit stays set until software clears it through the register port. Three positions of the cause word that carry no source (0, 30 and 31) read back as OR summaries of groups of source bits.

A source is pending when its cause bit and its mask bit are both set. On every cycle the block picks the lowest-numbered pending source. It registers three things: a request line, a valid flag and the five-bit number of the chosen source. When nothing is pending, the valid flag is low and the index is zero, and a handler reads this as a spurious entry.

Software sees two word registers behind a one-bit address. Address 0 selects the cause word and address 1 selects the mask word. A cause write clears only the bits written as zero. A handler can therefore acknowledge one source by writing all ones except that bit, and an event that arrives meanwhile is not lost.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After synchronous reset, the cause word and the mask word are all zeros, `irq_o` and `sel_vld_o` are low, `sel_idx_o` is 0 and `bus_rdata_o` is 0.
- R2: `src_evt_i[i]` high at a clock edge, for i in 1..29, sets cause bit i. The bit stays set until a cause write clears it.
- R3: A write to address 0 clears every source bit written as 0 and leaves every bit written as 1 unchanged. The written values of bits 0, 30 and 31 have no effect.
- R4: When an event on source i and a cause write clearing bit i occur at the same edge, bit i ends up set.
- R5: Cause bit 0 reads as the OR of source bits 29..1.
- R6: Cause bit 30 reads as the OR of source bits 29..26 and 20..1.
- R7: Cause bit 31 reads as the OR of source bits 25..1.
- R8: The summary bits are formed from the latched cause bits regardless of the mask word.
- R9: A write to address 1 stores all 32 bits of the mask word, and reads of address 1 return the last value written.
- R10: One cycle after (cause AND mask) over bits 1..29 is nonzero, `irq_o` and `sel_vld_o` are high. One cycle after it is zero, both are low.
- R11: `sel_idx_o` gives the lowest-numbered source i in 1..29 with cause and mask both set, one cycle after that state. When none is pending it is 0.
- R12: Levels on `src_evt_i` bits 0, 30 and 31 never change the cause word.
- R13: With `bus_re_i` high, `bus_rdata_o` after the edge holds the addressed word as it stood before that edge, including any write at the same edge. Without a read it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | 32 | Event lines; bits 1..29 are sources, other bits ignored |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 1 | 0 = cause word, 1 = mask word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |
| sel_vld_o | output | 1 | Registered flag: a source is selected |
| sel_idx_o | output | 5 | Registered number of the selected source |

## Verification
The bench builds the block with its defaults: a 32-bit word, sources 1 to 29, a five-bit index, and the summary groups at 29..26 with 20..1 and at 25..1. With these values, directed cases can place single sources inside and outside each summary group, such as 5, 22 and 27, to tell the three summaries apart. A sweep over every source index with a single-bit mask covers the priority order at each position. Long sparse random traffic, with concurrent clears and mask changes, drives the same-edge race between an event and an acknowledge many times.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    REG_CAUSE = 1'b0,
    REG_MASK  = 1'b1
  } irqc_reg_e;

endpackage

// File: rtl/irqc_cause_bank.sv
module irqc_cause_bank #(
  parameter int DATA_W = 32,
  parameter int SRC_LO = 1,
  parameter int SRC_HI = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] cause_o
);

  logic [DATA_W-1:0] src_bits;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] cause_d;

  // Positions that carry a real source
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_src
      if (b >= SRC_LO && b <= SRC_HI) begin : g_on
        assign src_bits[b] = 1'b1;
      end else begin : g_off
        assign src_bits[b] = 1'b0;
      end
    end
  endgenerate

  // New events override same-edge clears
  always_comb begin
    cause_d = ((cause_q & ~clr_i) | evt_i) & src_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
    end else begin
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary #(
  parameter int DATA_W = 32,
  parameter int SRC_LO = 1,
  parameter int SRC_HI = 29,
  parameter int ALL_POS = 0,
  parameter int GA_POS = 30,
  parameter int GA_HI0 = 29,
  parameter int GA_LO0 = 26,
  parameter int GA_HI1 = 20,
  parameter int GA_LO1 = 1,
  parameter int GB_POS = 31,
  parameter int GB_HI = 25,
  parameter int GB_LO = 1
) (
  input  logic [DATA_W-1:0] cause_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] sel_all;
  logic [DATA_W-1:0] sel_ga;
  logic [DATA_W-1:0] sel_gb;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_sel
      assign sel_all[b] = (b >= SRC_LO) && (b <= SRC_HI);
      assign sel_ga[b]  = ((b >= GA_LO0) && (b <= GA_HI0)) ||
                          ((b >= GA_LO1) && (b <= GA_HI1));
      assign sel_gb[b]  = (b >= GB_LO) && (b <= GB_HI);
    end
  endgenerate

  always_comb begin
    word_o          = cause_i & sel_all;
    word_o[ALL_POS] = |(cause_i & sel_all);
    word_o[GA_POS]  = |(cause_i & sel_ga);
    word_o[GB_POS]  = |(cause_i & sel_gb);
  end

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int DATA_W = 32,
  parameter int SRC_LO = 1,
  parameter int SRC_HI = 29,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pend_i,
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic             hit;
  logic [IDX_W-1:0] pick;

  // Scan downward so the lowest index is the last to assign
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = SRC_HI; i >= SRC_LO; i--) begin
      if (pend_i[i]) begin
        hit  = 1'b1;
        pick = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      idx_o <= '0;
    end else begin
      vld_o <= hit;
      idx_o <= pick;
    end
  end

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
  parameter int DATA_W = 32,
  parameter int SRC_LO = 1,
  parameter int SRC_HI = 29,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_evt_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic              bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sel_vld_o,
  output logic [IDX_W-1:0]  sel_idx_o
);

  import irqc_pkg::*;

  logic              cause_we;
  logic              mask_we;
  logic [DATA_W-1:0] cause_clr;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] cause_word;
  logic [DATA_W-1:0] pend;
  logic              vld_q;

  assign cause_we  = bus_we_i && (irqc_reg_e'(bus_addr_i) == REG_CAUSE);
  assign mask_we   = bus_we_i && (irqc_reg_e'(bus_addr_i) == REG_MASK);
  assign cause_clr = cause_we ? ~bus_wdata_i : '0;

  irqc_cause_bank #(
    .DATA_W (DATA_W),
    .SRC_LO (SRC_LO),
    .SRC_HI (SRC_HI)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (src_evt_i),
    .clr_i   (cause_clr),
    .cause_o (cause_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= bus_wdata_i;
    end
  end

  irqc_summary #(
    .DATA_W (DATA_W),
    .SRC_LO (SRC_LO),
    .SRC_HI (SRC_HI)
  ) u_sum (
    .cause_i (cause_q),
    .word_o  (cause_word)
  );

  assign pend = cause_q & mask_q;

  irqc_prio_pick #(
    .DATA_W (DATA_W),
    .SRC_LO (SRC_LO),
    .SRC_HI (SRC_HI),
    .IDX_W  (IDX_W)
  ) u_pick (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .vld_o  (vld_q),
    .idx_o  (sel_idx_o)
  );

  assign irq_o     = vld_q;
  assign sel_vld_o = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_re_i) begin
      bus_rdata_o <= (irqc_reg_e'(bus_addr_i) == REG_MASK) ? mask_q : cause_word;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int DATA_W = 32,
  parameter int SRC_LO = 1,
  parameter int SRC_HI = 29,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] src_evt_i,
  input logic [DATA_W-1:0] cause_q,
  input logic [DATA_W-1:0] cause_clr,
  input logic [DATA_W-1:0] mask_q,
  input logic              mask_we,
  input logic              irq_o,
  input logic              sel_vld_o,
  input logic [IDX_W-1:0]  sel_idx_o
);

  logic [DATA_W-1:0] src_bits;
  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      src_bits[b] = (b >= SRC_LO) && (b <= SRC_HI);
    end
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(cause_q) & ~$past(cause_clr) & ~cause_q) == '0));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(src_evt_i) & src_bits & ~cause_q) == '0));

  assert_no_stray_bits_R12: assert property (@(posedge clk) disable iff (rst)
    (cause_q & ~src_bits) == '0);

  assert_mask_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mask_we)) |-> $stable(mask_q));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == ($past(cause_q & mask_q & src_bits) != '0)));

  assert_irq_eq_vld_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o == sel_vld_o);

  assert_idle_idx_R11: assert property (@(posedge clk) disable iff (rst)
    !sel_vld_o |-> (sel_idx_o == '0));

  assert_idx_range_R11: assert property (@(posedge clk) disable iff (rst)
    sel_vld_o |-> ((int'(sel_idx_o) >= SRC_LO) && (int'(sel_idx_o) <= SRC_HI)));

endmodule

bind irq_cause_ctrl irqc_checker #(
  .DATA_W (DATA_W),
  .SRC_LO (SRC_LO),
  .SRC_HI (SRC_HI),
  .IDX_W  (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_evt_i (src_evt_i),
  .cause_q   (cause_q),
  .cause_clr (cause_clr),
  .mask_q    (mask_q),
  .mask_we   (mask_we),
  .irq_o     (irq_o),
  .sel_vld_o (sel_vld_o),
  .sel_idx_o (sel_idx_o)
);

// File: tb/irq_cause_ctrl_bench.sv
module irq_cause_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_evt_i = '0;
  logic        bus_we_i = 1'b0;
  logic        bus_re_i = 1'b0;
  logic        bus_addr_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  logic        sel_vld_o;
  logic [4:0]  sel_idx_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit [31:0] m_cause = '0;
  bit [31:0] m_mask = '0;
  bit [31:0] m_rd = '0;
  bit        m_irq = 0;
  int        m_idx = 0;

  always #2 clk = ~clk;

  irq_cause_ctrl u_irq_cause_ctrl (
    .clk         (clk),
    .rst         (rst),
    .src_evt_i   (src_evt_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .sel_vld_o   (sel_vld_o),
    .sel_idx_o   (sel_idx_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] model_word(input bit [31:0] c);
    bit [31:0] w;
    bit any = 0, ga = 0, gb = 0;
    w = '0;
    for (int i = 1; i <= 29; i++) begin
      if (c[i]) begin
        w[i] = 1'b1;
        any = 1;
        if (i >= 26 || i <= 20) ga = 1;
        if (i <= 25) gb = 1;
      end
    end
    w[0] = any; w[30] = ga; w[31] = gb;
    return w;
  endfunction

  // one clock: apply inputs, advance model, compare outputs
  task automatic cyc(input bit [31:0] evt, input bit we, input bit re,
                     input bit adr, input bit [31:0] wd);
    int first;
    bit [31:0] nc;
    src_evt_i = evt; bus_we_i = we; bus_re_i = re; bus_addr_i = adr; bus_wdata_i = wd;
    @(posedge clk);
    first = 0;
    for (int i = 29; i >= 1; i--) if (m_cause[i] && m_mask[i]) first = i;
    m_irq = (first != 0);
    m_idx = first;
    if (re) m_rd = adr ? m_mask : model_word(m_cause);
    nc = m_cause;
    if (we && !adr) nc = nc & wd;
    for (int i = 1; i <= 29; i++) if (evt[i]) nc[i] = 1'b1;
    nc[0] = 0; nc[30] = 0; nc[31] = 0;
    m_cause = nc;
    if (we && adr) m_mask = wd;
    #1;
    check(irq_o === m_irq, "R10 irq", 32'(irq_o), 32'(m_irq));
    check(sel_vld_o === m_irq, "R10 valid", 32'(sel_vld_o), 32'(m_irq));
    check(sel_idx_o === 5'(m_idx), "R11 index", 32'(sel_idx_o), 32'(m_idx));
    check(bus_rdata_o === m_rd, "R13 rdata", bus_rdata_o, m_rd);
  endtask

  task automatic idle(); cyc('0, 0, 0, 0, '0); endtask

  task automatic rd_chk(input bit adr, input bit [31:0] exp, input string req);
    cyc('0, 0, 1, adr, '0);
    check(bus_rdata_o === exp, req, bus_rdata_o, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1 reset state
    check(irq_o === 1'b0 && sel_vld_o === 1'b0, "R1 irq", 32'(irq_o), 32'd0);
    check(sel_idx_o === 5'd0, "R1 idx", 32'(sel_idx_o), 32'd0);
    check(bus_rdata_o === 32'd0, "R1 rdata", bus_rdata_o, 32'd0);
    rd_chk(0, 32'h0, "R1 cause");
    rd_chk(1, 32'h0, "R1 mask");

    // R2 sticky + R5/R6/R7 summaries, mask zero (R8)
    cyc(32'h0000_0020, 0, 0, 0, '0);
    repeat (3) idle();
    rd_chk(0, 32'hC000_0021, "R2 R5 R6 R7 R8 src5");
    cyc(32'hFFFF_FFFF, 1, 0, 0, 32'h0000_0000); // event 1..29 with full clear: R4
    rd_chk(0, 32'hFFFF_FFFF, "R4 all set");
    cyc('0, 1, 0, 0, 32'h0000_0000);
    rd_chk(0, 32'h0, "R3 clear all");
    cyc(32'h0800_0000, 0, 0, 0, '0);
    rd_chk(0, 32'h4800_0001, "R7 src27 no bit31");
    cyc('0, 1, 0, 0, 32'h0);
    cyc(32'h0040_0000, 0, 0, 0, '0);
    rd_chk(0, 32'h8040_0001, "R6 src22 no bit30");
    // R3 selective clear, summary writes ignored
    cyc(32'h0800_0020, 0, 0, 0, '0);
    cyc('0, 1, 0, 0, ~32'h0000_0020);
    rd_chk(0, 32'hC840_0001, "R3 clear src5 only");
    cyc('0, 1, 0, 0, 32'h0);
    cyc('0, 1, 0, 0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h0, "R3 summary write ignored");
    // R4 race on one bit
    cyc(32'h0000_0200, 1, 0, 0, 32'h0);
    rd_chk(0, 32'hC000_0201, "R4 src9 survives clear");
    cyc('0, 1, 0, 0, 32'h0);
    // R12 non-source lines ignored
    cyc(32'hC000_0001, 0, 0, 0, '0);
    idle();
    rd_chk(0, 32'h0, "R12 stray lines");
    // R9 mask storage, R13 read-before-write
    cyc('0, 1, 0, 1, 32'hA5A5_A5A5);
    rd_chk(1, 32'hA5A5_A5A5, "R9 mask readback");
    cyc('0, 1, 1, 1, 32'h0000_0000);
    check(bus_rdata_o === 32'hA5A5_A5A5, "R13 old value", bus_rdata_o, 32'hA5A5_A5A5);
    idle();
    check(bus_rdata_o === 32'hA5A5_A5A5, "R13 hold", bus_rdata_o, 32'hA5A5_A5A5);
    // R10/R11 priority
    cyc(32'h0000_0088, 1, 0, 1, 32'hFFFF_FFFF);
    idle();
    check(irq_o === 1'b1 && sel_idx_o === 5'd3, "R11 pick 3", 32'(sel_idx_o), 32'd3);
    cyc('0, 1, 0, 1, 32'hFFFF_FFF7);
    idle();
    check(sel_idx_o === 5'd7, "R11 pick 7", 32'(sel_idx_o), 32'd7);
    cyc('0, 1, 0, 1, 32'h0);
    idle();
    check(irq_o === 1'b0 && sel_idx_o === 5'd0, "R10 R11 spurious", 32'(sel_idx_o), 32'd0);
    cyc('0, 1, 0, 0, 32'h0);
    // sweep each source
    for (int i = 1; i <= 29; i++) begin
      cyc(32'(1) << i, 1, 0, 1, 32'(1) << i);
      idle();
      check(sel_idx_o === 5'(i), "R11 sweep", 32'(sel_idx_o), 32'(i));
      cyc('0, 1, 0, 0, 32'h0);
    end
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] e, d;
      bit we, re, ad;
      e = $urandom & $urandom & $urandom & $urandom;
      d = $urandom;
      we = ($urandom % 4) == 0;
      re = ($urandom % 2) == 0;
      ad = $urandom % 2;
      cyc(e, we, re, ad, d);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule